// File: doc/BRIEF.md
# Aliased Integer Register File

This block holds the integer architectural state of a 64-bit core: a bank of general registers, a bank of control registers with a packed status word, and the program counter with its instruction-set-mode flag. The general bank serves two combinational read ports and one clocked write port. The write port can store either a full 64-bit value or a 32-bit value that is widened by sign extension. The top entry is fixed at zero.

A handful of fixed general entries can also be reached through their own narrow ports. These ports cover a global base pointer, a vector base pointer, a return address, the two halves of a multiply accumulator, and a single-bit T flag. Each of these ports writes only its own field and keeps the rest of the entry. Control entry 0 is not stored in the control array; reads and writes of it go to the 32-bit status word. Three status bits have their own single-bit ports. A PC write removes bit 0 from the value and stores it as the mode flag.

Top module: `areg_file_top`

## Requirements
- R1: General index 63 always reads as zero on both read ports, and a general write to index 63 has no effect.
- R2: A full general write (`gw_narrow`=0) stores all 64 bits. The value can be read on both read ports from the cycle after the write edge, and reads are combinational in the index.
- R3: A narrow general write (`gw_narrow`=1) stores `gw_data[31:0]` sign-extended from bit 31 into all 64 bits. The compatibility 32-bit read is bits 31:0 of the read data.
- R4: Control entries 1 to 63 store full 64-bit writes. Reading control index 0 returns the status word zero-extended to 64 bits. A control write to index 0 loads bits 31:0 into the status word.
- R5: A PC write stores bit 0 of the value into `mode_q` and stores the value with bit 0 cleared into `pc_q`. No other input changes `mode_q`.
- R6: The global-base view is entry 16, the return view is entry 18 and the vector-base view is entry 20. Each view reads bits 31:0 of its entry and writes a sign-extended 32-bit value.
- R7: Entry 17 is the accumulator. Its low view is bits 31:0 and its high view is bits 63:32. Writing one half leaves the other half unchanged, and both halves may be written in the same cycle.
- R8: The T flag is bit 0 of entry 19. Writing the flag changes only bit 0.
- R9: In the status word, bit 1 is the S flag, bit 8 is the Q flag and bit 9 is the M flag. A flag write changes only its own bit. A control write to index 0 in the same cycle takes priority over the flag writes.
- R10: When a general write and a view write target the same entry in the same cycle, the general write decides the entry's value.
- R11: Synchronous reset clears every general and control entry, the status word, the PC and the mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 6 | Read port A index |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 6 | Read port B index |
| rb_data | output | 64 | Read port B data |
| gw_en | input | 1 | General write enable |
| gw_idx | input | 6 | General write index |
| gw_narrow | input | 1 | 1: sign-extend gw_data[31:0] |
| gw_data | input | 64 | General write data |
| gb_we | input | 1 | Global-base view write enable |
| gb_wd | input | 32 | Global-base view write data |
| gb_q | output | 32 | Global-base view |
| rt_we | input | 1 | Return view write enable |
| rt_wd | input | 32 | Return view write data |
| rt_q | output | 32 | Return view |
| vb_we | input | 1 | Vector-base view write enable |
| vb_wd | input | 32 | Vector-base view write data |
| vb_q | output | 32 | Vector-base view |
| acl_we | input | 1 | Accumulator low write enable |
| acl_wd | input | 32 | Accumulator low write data |
| acl_q | output | 32 | Accumulator low half |
| ach_we | input | 1 | Accumulator high write enable |
| ach_wd | input | 32 | Accumulator high write data |
| ach_q | output | 32 | Accumulator high half |
| tf_we | input | 1 | T flag write enable |
| tf_wd | input | 1 | T flag write value |
| tf_q | output | 1 | T flag |
| cr_idx | input | 6 | Control read index |
| cr_data | output | 64 | Control read data |
| cw_en | input | 1 | Control write enable |
| cw_idx | input | 6 | Control write index |
| cw_data | input | 64 | Control write data |
| stat_q | output | 32 | Status word |
| sf_we | input | 1 | S flag write enable |
| sf_wd | input | 1 | S flag value |
| qf_we | input | 1 | Q flag write enable |
| qf_wd | input | 1 | Q flag value |
| mf_we | input | 1 | M flag write enable |
| mf_wd | input | 1 | M flag value |
| sf_q | output | 1 | S flag |
| qf_q | output | 1 | Q flag |
| mf_q | output | 1 | M flag |
| pc_we | input | 1 | PC write enable |
| pc_wd | input | 64 | PC write value |
| pc_q | output | 64 | Program counter, bit 0 always zero |
| mode_q | output | 1 | Instruction-set-mode flag |

## Verification
The checker watches several rules on every cycle. It checks that index 63 reads as zero, that a full write can be read back through a port pointing at the same index, and that a PC write splits into `pc_q` and `mode_q`. It also checks that `mode_q` holds between PC writes, that a lone half write of the accumulator keeps the other half, that a T-flag write lands, and that an S-flag write lands unless a status write overrides it. Some rules only the bench scenarios can show. These are sign extension of narrow and view writes, the redirect of control index 0, the priority of a general write over a view write, and the reset state. Each of them needs a chosen value and a read-back afterwards.

// File: rtl/areg_pkg.sv
package areg_pkg;
  // fixed entries reached through the view ports
  localparam int unsigned AL_GBASE = 16;
  localparam int unsigned AL_ACC   = 17;
  localparam int unsigned AL_RET   = 18;
  localparam int unsigned AL_TFLAG = 19;
  localparam int unsigned AL_VBASE = 20;
  // status word bit positions
  localparam int unsigned ST_S = 1;
  localparam int unsigned ST_Q = 8;
  localparam int unsigned ST_M = 9;
endpackage

// File: rtl/areg_gpr_bank.sv
module areg_gpr_bank #(
  parameter int XLEN   = 64,
  parameter int HALF_W = 32,
  parameter int NREG   = 64,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     ra_idx,
  output logic [XLEN-1:0]   ra_data,
  input  logic [IW-1:0]     rb_idx,
  output logic [XLEN-1:0]   rb_data,
  input  logic              gw_en,
  input  logic [IW-1:0]     gw_idx,
  input  logic              gw_narrow,
  input  logic [XLEN-1:0]   gw_data,
  input  logic              gb_we,
  input  logic [HALF_W-1:0] gb_wd,
  input  logic              rt_we,
  input  logic [HALF_W-1:0] rt_wd,
  input  logic              vb_we,
  input  logic [HALF_W-1:0] vb_wd,
  input  logic              acl_we,
  input  logic [HALF_W-1:0] acl_wd,
  input  logic              ach_we,
  input  logic [HALF_W-1:0] ach_wd,
  input  logic              tf_we,
  input  logic              tf_wd,
  output logic [HALF_W-1:0] gb_q,
  output logic [HALF_W-1:0] rt_q,
  output logic [HALF_W-1:0] vb_q,
  output logic [HALF_W-1:0] acl_q,
  output logic [HALF_W-1:0] ach_q,
  output logic              tf_q
);
  import areg_pkg::*;
  localparam int ZERO_IDX = NREG - 1;
  localparam int EXT_W    = XLEN - HALF_W;

  logic [XLEN-1:0] mem_q [NREG];
  logic [XLEN-1:0] gw_full;

  function automatic logic [XLEN-1:0] sext(input logic [HALF_W-1:0] v);
    return {{EXT_W{v[HALF_W-1]}}, v};
  endfunction

  assign gw_full = gw_narrow ? sext(gw_data[HALF_W-1:0]) : gw_data;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == ZERO_IDX) begin : g_zero
      always_ff @(posedge clk) mem_q[i] <= '0;
    end else begin : g_live
      logic [XLEN-1:0] nxt;
      always_comb begin
        nxt = mem_q[i];
        // view writes first, general write overrides (R10)
        if (i == AL_GBASE && gb_we) nxt = sext(gb_wd);
        if (i == AL_RET   && rt_we) nxt = sext(rt_wd);
        if (i == AL_VBASE && vb_we) nxt = sext(vb_wd);
        if (i == AL_ACC) begin
          if (acl_we) nxt[HALF_W-1:0]    = acl_wd;
          if (ach_we) nxt[XLEN-1:HALF_W] = ach_wd;
        end
        if (i == AL_TFLAG && tf_we) nxt[0] = tf_wd;
        if (gw_en && gw_idx == IW'(i)) nxt = gw_full;
      end
      always_ff @(posedge clk) begin
        if (rst) mem_q[i] <= '0;
        else     mem_q[i] <= nxt;
      end
    end
  end

  assign ra_data = (ra_idx == IW'(ZERO_IDX)) ? '0 : mem_q[ra_idx];
  assign rb_data = (rb_idx == IW'(ZERO_IDX)) ? '0 : mem_q[rb_idx];

  assign gb_q  = mem_q[AL_GBASE][HALF_W-1:0];
  assign rt_q  = mem_q[AL_RET][HALF_W-1:0];
  assign vb_q  = mem_q[AL_VBASE][HALF_W-1:0];
  assign acl_q = mem_q[AL_ACC][HALF_W-1:0];
  assign ach_q = mem_q[AL_ACC][XLEN-1:HALF_W];
  assign tf_q  = mem_q[AL_TFLAG][0];
endmodule

// File: rtl/areg_ctl_bank.sv
module areg_ctl_bank #(
  parameter int XLEN   = 64,
  parameter int STAT_W = 32,
  parameter int NCR    = 64,
  localparam int IW    = $clog2(NCR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     cr_idx,
  output logic [XLEN-1:0]   cr_data,
  input  logic              cw_en,
  input  logic [IW-1:0]     cw_idx,
  input  logic [XLEN-1:0]   cw_data,
  input  logic              sf_we,
  input  logic              sf_wd,
  input  logic              qf_we,
  input  logic              qf_wd,
  input  logic              mf_we,
  input  logic              mf_wd,
  output logic [STAT_W-1:0] stat_q
);
  import areg_pkg::*;

  logic [XLEN-1:0]   cr_q [NCR];
  logic [STAT_W-1:0] stat_nxt;
  logic              stat_hit;

  for (genvar i = 0; i < NCR; i++) begin : g_cr
    if (i == 0) begin : g_redir
      always_ff @(posedge clk) cr_q[i] <= '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                            cr_q[i] <= '0;
        else if (cw_en && cw_idx == IW'(i)) cr_q[i] <= cw_data;
      end
    end
  end

  assign stat_hit = cw_en && (cw_idx == '0);

  always_comb begin
    stat_nxt = stat_q;
    if (sf_we) stat_nxt[ST_S] = sf_wd;
    if (qf_we) stat_nxt[ST_Q] = qf_wd;
    if (mf_we) stat_nxt[ST_M] = mf_wd;
    if (stat_hit) stat_nxt = cw_data[STAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end

  assign cr_data = (cr_idx == '0) ? {{(XLEN-STAT_W){1'b0}}, stat_q} : cr_q[cr_idx];
endmodule

// File: rtl/areg_pc_unit.sv
module areg_pc_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_wd,
  output logic [XLEN-1:0] pc_q,
  output logic            mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mode_q <= 1'b0;
    end else if (pc_we) begin
      pc_q   <= {pc_wd[XLEN-1:1], 1'b0};
      mode_q <= pc_wd[0];
    end
  end
endmodule

// File: rtl/areg_file_top.sv
module areg_file_top #(
  parameter int XLEN   = 64,
  parameter int HALF_W = 32,
  parameter int NREG   = 64,
  parameter int NCR    = 64,
  localparam int GIW   = $clog2(NREG),
  localparam int CIW   = $clog2(NCR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GIW-1:0]    ra_idx,
  output logic [XLEN-1:0]   ra_data,
  input  logic [GIW-1:0]    rb_idx,
  output logic [XLEN-1:0]   rb_data,
  input  logic              gw_en,
  input  logic [GIW-1:0]    gw_idx,
  input  logic              gw_narrow,
  input  logic [XLEN-1:0]   gw_data,
  input  logic              gb_we,
  input  logic [HALF_W-1:0] gb_wd,
  output logic [HALF_W-1:0] gb_q,
  input  logic              rt_we,
  input  logic [HALF_W-1:0] rt_wd,
  output logic [HALF_W-1:0] rt_q,
  input  logic              vb_we,
  input  logic [HALF_W-1:0] vb_wd,
  output logic [HALF_W-1:0] vb_q,
  input  logic              acl_we,
  input  logic [HALF_W-1:0] acl_wd,
  output logic [HALF_W-1:0] acl_q,
  input  logic              ach_we,
  input  logic [HALF_W-1:0] ach_wd,
  output logic [HALF_W-1:0] ach_q,
  input  logic              tf_we,
  input  logic              tf_wd,
  output logic              tf_q,
  input  logic [CIW-1:0]    cr_idx,
  output logic [XLEN-1:0]   cr_data,
  input  logic              cw_en,
  input  logic [CIW-1:0]    cw_idx,
  input  logic [XLEN-1:0]   cw_data,
  output logic [HALF_W-1:0] stat_q,
  input  logic              sf_we,
  input  logic              sf_wd,
  input  logic              qf_we,
  input  logic              qf_wd,
  input  logic              mf_we,
  input  logic              mf_wd,
  output logic              sf_q,
  output logic              qf_q,
  output logic              mf_q,
  input  logic              pc_we,
  input  logic [XLEN-1:0]   pc_wd,
  output logic [XLEN-1:0]   pc_q,
  output logic              mode_q
);
  import areg_pkg::*;

  areg_gpr_bank #(.XLEN(XLEN), .HALF_W(HALF_W), .NREG(NREG)) gpr_i (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .gw_en(gw_en), .gw_idx(gw_idx), .gw_narrow(gw_narrow), .gw_data(gw_data),
    .gb_we(gb_we), .gb_wd(gb_wd), .rt_we(rt_we), .rt_wd(rt_wd),
    .vb_we(vb_we), .vb_wd(vb_wd), .acl_we(acl_we), .acl_wd(acl_wd),
    .ach_we(ach_we), .ach_wd(ach_wd), .tf_we(tf_we), .tf_wd(tf_wd),
    .gb_q(gb_q), .rt_q(rt_q), .vb_q(vb_q), .acl_q(acl_q), .ach_q(ach_q),
    .tf_q(tf_q)
  );

  areg_ctl_bank #(.XLEN(XLEN), .STAT_W(HALF_W), .NCR(NCR)) ctl_i (
    .clk(clk), .rst(rst),
    .cr_idx(cr_idx), .cr_data(cr_data),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
    .sf_we(sf_we), .sf_wd(sf_wd), .qf_we(qf_we), .qf_wd(qf_wd),
    .mf_we(mf_we), .mf_wd(mf_wd), .stat_q(stat_q)
  );

  areg_pc_unit #(.XLEN(XLEN)) pc_i (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_wd(pc_wd),
    .pc_q(pc_q), .mode_q(mode_q)
  );

  assign sf_q = stat_q[ST_S];
  assign qf_q = stat_q[ST_Q];
  assign mf_q = stat_q[ST_M];
endmodule

// File: rtl/areg_file_chk.sv
module areg_file_chk #(
  parameter int XLEN   = 64,
  parameter int HALF_W = 32,
  parameter int NREG   = 64,
  parameter int NCR    = 64,
  localparam int GIW   = $clog2(NREG),
  localparam int CIW   = $clog2(NCR)
) (
  input logic              clk,
  input logic              rst,
  input logic [GIW-1:0]    ra_idx,
  input logic [XLEN-1:0]   ra_data,
  input logic [GIW-1:0]    rb_idx,
  input logic [XLEN-1:0]   rb_data,
  input logic              gw_en,
  input logic [GIW-1:0]    gw_idx,
  input logic              gw_narrow,
  input logic [XLEN-1:0]   gw_data,
  input logic              acl_we,
  input logic              ach_we,
  input logic [HALF_W-1:0] acl_q,
  input logic [HALF_W-1:0] ach_q,
  input logic              tf_we,
  input logic              tf_wd,
  input logic              tf_q,
  input logic              cw_en,
  input logic [CIW-1:0]    cw_idx,
  input logic              sf_we,
  input logic              sf_wd,
  input logic              sf_q,
  input logic              pc_we,
  input logic [XLEN-1:0]   pc_wd,
  input logic [XLEN-1:0]   pc_q,
  input logic              mode_q
);
  import areg_pkg::*;
  localparam logic [GIW-1:0] ZI = GIW'(NREG - 1);

  // R1
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == ZI) |-> (ra_data == '0 && (rb_idx != ZI || rb_data == '0)));

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (gw_en && !gw_narrow && gw_idx != ZI)
    |=> (ra_idx != $past(gw_idx) || ra_data == $past(gw_data)));

  // R5
  pc_split_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> (pc_q == {$past(pc_wd[XLEN-1:1]), 1'b0} && mode_q == $past(pc_wd[0])));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> $stable(mode_q));

  // R7
  acc_keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acl_we && !ach_we && !(gw_en && gw_idx == GIW'(AL_ACC))) |=> $stable(ach_q));

  // R7
  acc_keep_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (ach_we && !acl_we && !(gw_en && gw_idx == GIW'(AL_ACC))) |=> $stable(acl_q));

  // R8
  tflag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tf_we && !(gw_en && gw_idx == GIW'(AL_TFLAG))) |=> (tf_q == $past(tf_wd)));

  // R9
  sflag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sf_we && !(cw_en && cw_idx == '0)) |=> (sf_q == $past(sf_wd)));
endmodule

bind areg_file_top areg_file_chk #(.XLEN(XLEN), .HALF_W(HALF_W), .NREG(NREG), .NCR(NCR)) chk_i (.*);

// File: tb/areg_file_top_tb_top.sv
`timescale 1ns/1ps
module areg_file_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [5:0]  ra_idx = '0, rb_idx = '0, gw_idx = '0, cr_idx = '0, cw_idx = '0;
  logic [63:0] ra_data, rb_data, gw_data = '0, cr_data, cw_data = '0, pc_wd = '0, pc_q;
  logic        gw_en = 0, gw_narrow = 0, gb_we = 0, rt_we = 0, vb_we = 0;
  logic        acl_we = 0, ach_we = 0, tf_we = 0, tf_wd = 0, tf_q, cw_en = 0;
  logic [31:0] gb_wd = '0, rt_wd = '0, vb_wd = '0, acl_wd = '0, ach_wd = '0;
  logic [31:0] gb_q, rt_q, vb_q, acl_q, ach_q, stat_q;
  logic        sf_we = 0, sf_wd = 0, qf_we = 0, qf_wd = 0, mf_we = 0, mf_wd = 0;
  logic        sf_q, qf_q, mf_q, pc_we = 0, mode_q;

  areg_file_top dut_i (.*);

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    gw_en = 0; gw_narrow = 0; gb_we = 0; rt_we = 0; vb_we = 0; acl_we = 0;
    ach_we = 0; tf_we = 0; cw_en = 0; sf_we = 0; qf_we = 0; mf_we = 0; pc_we = 0;
  endtask

  task automatic rdg(input logic [5:0] idx);
    ra_idx = idx; rb_idx = idx; #1;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // {idx, narrow, write data, expected read}
  localparam logic [134:0] VEC [6] = '{
    {6'd5,  1'b0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    {6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {6'd7,  1'b1, 64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_8000_0001},
    {6'd8,  1'b1, 64'h1234_5678_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF},
    {6'd0,  1'b0, 64'hA5A5_5A5A_A5A5_5A5A, 64'hA5A5_5A5A_A5A5_5A5A},
    {6'd62, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001}
  };

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    @(posedge clk); @(posedge clk); #2; rst = 0;

    // R11 reset state
    rdg(6'd5);  chk("R11 gpr", ra_data, 64'h0);
    cr_idx = 6'd3; #1; chk("R11 ctl", cr_data, 64'h0);
    chk("R11 stat", {32'h0, stat_q}, 64'h0);
    chk("R11 pc", pc_q, 64'h0);
    chk("R11 mode", {63'h0, mode_q}, 64'h0);

    // R1 R2 R3 vector table
    foreach (VEC[k]) begin
      gw_en = 1; gw_idx = VEC[k][134:129]; gw_narrow = VEC[k][128];
      gw_data = VEC[k][127:64];
      step();
      rdg(VEC[k][134:129]);
      chk("R1/R2/R3 port A", ra_data, VEC[k][63:0]);
      chk("R1/R2/R3 port B", rb_data, VEC[k][63:0]);
    end
    rdg(6'd7); chk("R3 compat read", {32'h0, ra_data[31:0]}, 64'h8000_0001);

    // R5 PC split
    pc_we = 1; pc_wd = 64'h0000_1000_0000_1235; step();
    chk("R5 pc", pc_q, 64'h0000_1000_0000_1234);
    chk("R5 mode", {63'h0, mode_q}, 64'h1);
    gw_en = 1; gw_idx = 6'd9; gw_data = 64'h1; step();
    chk("R5 mode hold", {63'h0, mode_q}, 64'h1);
    pc_we = 1; pc_wd = 64'h2000; step();
    chk("R5 mode clear", {63'h0, mode_q}, 64'h0);
    chk("R5 pc even", pc_q, 64'h2000);

    // R6 views
    gb_we = 1; gb_wd = 32'h8000_0010;
    rt_we = 1; rt_wd = 32'hFFFF_FFFF;
    vb_we = 1; vb_wd = 32'h0000_1234; step();
    rdg(6'd16); chk("R6 gbase entry", ra_data, 64'hFFFF_FFFF_8000_0010);
    chk("R6 gbase view", {32'h0, gb_q}, 64'h8000_0010);
    rdg(6'd18); chk("R6 ret entry", ra_data, 64'hFFFF_FFFF_FFFF_FFFF);
    rdg(6'd20); chk("R6 vbase entry", ra_data, 64'h0000_0000_0000_1234);
    chk("R6 vbase view", {32'h0, vb_q}, 64'h1234);

    // R7 accumulator halves
    gw_en = 1; gw_idx = 6'd17; gw_data = 64'h1111_2222_3333_4444; step();
    acl_we = 1; acl_wd = 32'hAAAA_BBBB; step();
    rdg(6'd17); chk("R7 low write", ra_data, 64'h1111_2222_AAAA_BBBB);
    ach_we = 1; ach_wd = 32'hCCCC_DDDD; step();
    rdg(6'd17); chk("R7 high write", ra_data, 64'hCCCC_DDDD_AAAA_BBBB);
    acl_we = 1; acl_wd = 32'h1; ach_we = 1; ach_wd = 32'h2; step();
    chk("R7 both halves", {ach_q, acl_q}, 64'h0000_0002_0000_0001);

    // R8 T flag
    gw_en = 1; gw_idx = 6'd19; gw_data = 64'hFFFF_FFFF_FFFF_FFFE; step();
    tf_we = 1; tf_wd = 1; step();
    rdg(6'd19); chk("R8 set", ra_data, 64'hFFFF_FFFF_FFFF_FFFF);
    tf_we = 1; tf_wd = 0; step();
    rdg(6'd19); chk("R8 clear", ra_data, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R8 view", {63'h0, tf_q}, 64'h0);

    // R10 general write beats view write
    gw_en = 1; gw_idx = 6'd16; gw_data = 64'h5; gb_we = 1; gb_wd = 32'h99; step();
    rdg(6'd16); chk("R10 priority", ra_data, 64'h5);
    gw_en = 1; gw_idx = 6'd17; gw_data = 64'h7; acl_we = 1; acl_wd = 32'h99; step();
    rdg(6'd17); chk("R10 acc priority", ra_data, 64'h7);

    // R4 control bank and redirect
    cw_en = 1; cw_idx = 6'd3; cw_data = 64'hCAFE_F00D_1234_5678; step();
    cr_idx = 6'd3; #1; chk("R4 ctl store", cr_data, 64'hCAFE_F00D_1234_5678);
    cw_en = 1; cw_idx = 6'd0; cw_data = 64'hFFFF_FFFF_0000_0302; step();
    cr_idx = 6'd0; #1; chk("R4 ctl0 redirect", cr_data, 64'h0000_0000_0000_0302);
    chk("R9 flags from stat", {61'h0, mf_q, qf_q, sf_q}, 64'h7);

    // R9 flag writes
    mf_we = 1; mf_wd = 0; step();
    chk("R9 M clear", {32'h0, stat_q}, 64'h102);
    qf_we = 1; qf_wd = 0; step();
    chk("R9 Q clear", {32'h0, stat_q}, 64'h2);
    cw_en = 1; cw_idx = 6'd0; cw_data = 64'hF0F0_0000; step();
    sf_we = 1; sf_wd = 1; step();
    chk("R9 S set keeps others", {32'h0, stat_q}, 64'hF0F0_0002);
    cw_en = 1; cw_idx = 6'd0; cw_data = 64'h10; sf_we = 1; sf_wd = 1; step();
    chk("R9 ctl write priority", {32'h0, stat_q}, 64'h10);

    // R11 reset again
    rst = 1; step(); rst = 0;
    rdg(6'd5); chk("R11 re-reset gpr", ra_data, 64'h0);
    cr_idx = 6'd3; #1; chk("R11 re-reset ctl", cr_data, 64'h0);
    chk("R11 re-reset pc", pc_q, 64'h0);

    finish_run();
  end
endmodule